// File: doc/BRIEF.md
# Register-Mapped Vectored Interrupt Controller

This block gathers up to 32 interrupt request lines into one processor interrupt output. Each line is fixed at build time as either edge-sensitive or level-sensitive. A latched status bit records every request, whether or not that line is enabled. The pending view is the status ANDed with a per-line enable mask. A processor on a simple word-wide register port reads status, pending and enable. It changes enable bits with separate set and clear writes, so no read-modify-write is needed. It clears latched requests by writing ones to an acknowledge location.

A vector register gives the number of the most urgent pending line, and reads all ones when nothing is pending. A two-bit master control gates the output line, which asserts only when both control bits are on and at least one line is pending. Reads and the output line are registered: each shows the state the registers held at the previous clock edge.

Top module: `irq_vector_ctrl`

## Requirements
- R1: The port selects a register by a 3-bit word index (byte offset = 4 × index): 0 status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector, 7 master control. `bus_rdata` shows, one clock later, the register selected by `bus_addr` in the cycle before. Indices 3, 4 and 5 read as zero, and writes to indices 0, 1, 2 and 6 change nothing.
- R2: Writing to index 4 sets every enable bit where the write data holds a one and leaves the others as they were.
- R3: Writing to index 5 clears every enable bit where the write data holds a one and leaves the others as they were.
- R4: Writing to index 3 clears each status bit where the data holds a one. A request that arrives in the same cycle as its own acknowledge wins, so the bit stays set.
- R5: Parameter KIND_MASK bit i = 1 makes line i edge-sensitive: a 0-to-1 change sets the status bit once, and a held-high line does not set it again after an acknowledge. Bit i = 0 makes line i level-sensitive: the status bit is set on every clock while the line is high, so an acknowledge does not clear it while the line stays high.
- R6: Status bits latch whether or not the line is enabled. The pending register (index 1) always equals status AND enable.
- R7: The vector register holds the index of the lowest-numbered pending bit, zero-extended to 32 bits, or 0xFFFFFFFF when no bit is pending.
- R8: In the master control register, bit 0 is the global enable and bit 1 is the output-line enable. `irq_out` is high one clock after a cycle in which both bits were 1 and pending was nonzero, and is low otherwise.
- R9: Status, enable and pending bits at positions NUM_IN and above always read zero, even after a write of ones. KIND_MASK bits above NUM_IN have no effect.
- R10: While `rst` is high at a clock edge, status, enable, master control, `bus_rdata` and `irq_out` all become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per clock in which it is high |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | NUM_IN | Interrupt request lines |
| irq_out | output | 1 | Registered processor interrupt line |

## Verification
Two functions can collide in one clock: an acknowledge write to a status bit, and a new request on that same line. The bench provokes this by driving the acknowledge write and a rising edge on an edge-sensitive line at the same clock edge, and by acknowledging a level line that is still held high. Both cases must leave the bit set. A behavioural model then replays long stretches of random writes and line activity, so that acknowledges, enable writes and input edges overlap freely. Every clock it compares the read data and the output line against the model's own computation.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [2:0] {
    RG_STAT = 3'd0,
    RG_PEND = 3'd1,
    RG_EN   = 3'd2,
    RG_ACK  = 3'd3,
    RG_SET  = 3'd4,
    RG_CLR  = 3'd5,
    RG_VEC  = 3'd6,
    RG_MST  = 3'd7
  } reg_sel_e;

  // ones in the low n bit positions of a data word
  function automatic logic [DATA_W-1:0] live_mask(input int n);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/irqc_latch.sv
module irqc_latch #(
  parameter int          NUM_IN    = 32,
  parameter logic [31:0] KIND_MASK = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IN-1:0] irq_in,
  input  logic [NUM_IN-1:0] ack,
  output logic [NUM_IN-1:0] status
);
  logic [NUM_IN-1:0] hit;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_line
    if (KIND_MASK[i]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= irq_in[i];
      end
      assign hit[i] = irq_in[i] & ~prev_q;
    end else begin : g_level
      assign hit[i] = irq_in[i];
    end
  end

  // a new request outranks an acknowledge in the same cycle
  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= (status & ~ack) | hit;
  end
endmodule

// File: rtl/irqc_enable.sv
module irqc_enable #(
  parameter int NUM_IN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_stb,
  input  logic              clr_stb,
  input  logic [NUM_IN-1:0] wmask,
  output logic [NUM_IN-1:0] en
);
  always_ff @(posedge clk) begin
    if (rst)          en <= '0;
    else if (set_stb) en <= en | wmask;
    else if (clr_stb) en <= en & ~wmask;
  end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int NUM_IN = 32,
  parameter int DATA_W = 32
) (
  input  logic [NUM_IN-1:0] pend,
  output logic [DATA_W-1:0] vec
);
  always_comb begin
    vec = '1;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (pend[i]) vec = DATA_W'(i);
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int          NUM_IN    = 32,
  parameter logic [31:0] KIND_MASK = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  input  logic [NUM_IN-1:0] irq_in,
  output logic              irq_out
);
  reg_sel_e          sel;
  logic [NUM_IN-1:0] ack, status, en, pend, wmask;
  logic [DATA_W-1:0] stat_x, en_x, pend_x, vec;
  logic [1:0]        mst_q;
  logic [DATA_W-1:0] rd_q;
  logic              irq_q;

  assign sel   = reg_sel_e'(bus_addr);
  assign wmask = bus_wdata[NUM_IN-1:0];
  assign ack   = (bus_we && sel == RG_ACK) ? wmask : '0;
  assign pend  = status & en;

  irqc_latch #(.NUM_IN(NUM_IN), .KIND_MASK(KIND_MASK)) u_latch (
    .clk(clk), .rst(rst), .irq_in(irq_in), .ack(ack), .status(status)
  );

  irqc_enable #(.NUM_IN(NUM_IN)) u_enable (
    .clk(clk), .rst(rst),
    .set_stb(bus_we && sel == RG_SET),
    .clr_stb(bus_we && sel == RG_CLR),
    .wmask(wmask), .en(en)
  );

  irqc_prio #(.NUM_IN(NUM_IN), .DATA_W(DATA_W)) u_prio (
    .pend(pend), .vec(vec)
  );

  always_comb begin
    stat_x = '0;
    en_x   = '0;
    pend_x = '0;
    stat_x[NUM_IN-1:0] = status;
    en_x[NUM_IN-1:0]   = en;
    pend_x[NUM_IN-1:0] = pend;
  end

  always_ff @(posedge clk) begin
    if (rst)                          mst_q <= 2'b00;
    else if (bus_we && sel == RG_MST) mst_q <= bus_wdata[1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= (|pend) && (&mst_q);
      unique case (sel)
        RG_STAT: rd_q <= stat_x;
        RG_PEND: rd_q <= pend_x;
        RG_EN:   rd_q <= en_x;
        RG_VEC:  rd_q <= vec;
        RG_MST:  rd_q <= {{(DATA_W-2){1'b0}}, mst_q};
        default: rd_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rd_q;
  assign irq_out   = irq_q;
endmodule

// File: rtl/irqc_check.sv
module irqc_check
  import irqc_pkg::*;
#(
  parameter int NUM_IN = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_we,
  input logic [31:0]       bus_rdata,
  input logic              irq_out,
  input logic [DATA_W-1:0] stat_x,
  input logic [DATA_W-1:0] en_x,
  input logic [1:0]        mst_q
);
  localparam logic [DATA_W-1:0] LIVE = live_mask(NUM_IN);

  // R2
  a_r2_set_enable: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(bus_we && bus_addr == 3'd4))
      |-> ((en_x & $past(bus_wdata) & LIVE) == ($past(bus_wdata) & LIVE)));

  // R3
  a_r3_clear_enable: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(bus_we && bus_addr == 3'd5))
      |-> ((en_x & $past(bus_wdata)) == '0));

  // R4: a status bit only drops when it was acknowledged
  a_r4_status_hold: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |->
      (($past(stat_x) & ~(($past(bus_we && bus_addr == 3'd3)) ? $past(bus_wdata) : '0)
        & ~stat_x) == '0));

  // R7
  a_r7_vec_none: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(bus_addr == 3'd6 && (stat_x & en_x) == '0))
      |-> (bus_rdata == '1));

  // R8
  a_r8_gate: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> ($past(mst_q) == 2'b11));

  // R9
  a_r9_upper_zero: assert property (@(posedge clk) disable iff (rst)
    ((stat_x | en_x) & ~LIVE) == '0);
endmodule

bind irq_vector_ctrl irqc_check #(.NUM_IN(NUM_IN)) u_check (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_rdata(bus_rdata), .irq_out(irq_out),
  .stat_x(stat_x), .en_x(en_x), .mst_q(mst_q)
);

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  localparam int          NIN  = 24;
  localparam logic [31:0] KIND = 32'hFF00_F0F0;
  localparam logic [31:0] LIVE = 32'h00FF_FFFF;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [2:0]     bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic           bus_we = 1'b0;
  logic [31:0]    bus_rdata;
  logic [NIN-1:0] irq_in = '0;
  logic           irq_out;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_vector_ctrl #(.NUM_IN(NIN), .KIND_MASK(KIND)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .irq_in(irq_in), .irq_out(irq_out)
  );

  // behavioural reference model
  logic [31:0] m_st, m_en, m_prev, m_rd;
  logic [1:0]  m_me;
  logic        m_irq;
  initial begin
    m_st = 0; m_en = 0; m_prev = 0; m_rd = 0; m_me = 0; m_irq = 0;
  end

  always @(posedge clk) begin
    logic [31:0] pend, ack, nst, inw;
    int idx;
    if (rst) begin
      m_st = 0; m_en = 0; m_me = 0; m_prev = 0; m_rd = 0; m_irq = 0;
    end else begin
      idx  = int'(bus_addr);
      inw  = 32'(irq_in);
      pend = m_st & m_en;
      m_irq = (pend != 0) && (m_me == 2'd3);
      case (idx)
        0: m_rd = m_st;
        1: m_rd = pend;
        2: m_rd = m_en;
        6: begin
          m_rd = 32'hFFFF_FFFF;
          for (int i = 0; i < 32; i++)
            if (pend[i] && m_rd == 32'hFFFF_FFFF) m_rd = i;
        end
        7: m_rd = {30'd0, m_me};
        default: m_rd = 0;
      endcase
      ack = (bus_we && idx == 3) ? (bus_wdata & LIVE) : 32'd0;
      nst = m_st & ~ack;
      for (int i = 0; i < NIN; i++) begin
        if (KIND[i]) begin
          if (inw[i] && !m_prev[i]) nst[i] = 1'b1;
        end else if (inw[i]) nst[i] = 1'b1;
      end
      m_st   = nst;
      m_prev = inw;
      if (bus_we && idx == 4) m_en = (m_en | bus_wdata) & LIVE;
      if (bus_we && idx == 5) m_en = m_en & ~bus_wdata;
      if (bus_we && idx == 7) m_me = bus_wdata[1:0];
    end
  end

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      vectors++;
      if (bus_rdata !== m_rd || irq_out !== m_irq) begin
        miscompares++;
        $display("FAIL R1/R8 model: rdata=%h exp=%h irq=%b exp=%b",
                 bus_rdata, m_rd, irq_out, m_irq);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R10 reset state
    chk("R10 irq_out", 32'(irq_out), 0);
    rd(3'd0, v); chk("R10 status", v, 0);
    rd(3'd2, v); chk("R10 enable", v, 0);
    rd(3'd7, v); chk("R10 master", v, 0);

    // R2 / R3 / R9 enable handling
    wr(3'd4, 32'h00F0_00FF); rd(3'd2, v); chk("R2 set-enable", v, 32'h00F0_00FF);
    wr(3'd5, 32'h0000_000F); rd(3'd2, v); chk("R3 clear-enable", v, 32'h00F0_00F0);
    wr(3'd4, 32'hFF00_0000); rd(3'd2, v); chk("R9 upper enable", v, 32'h00F0_00F0);
    wr(3'd2, 32'h0000_0000); rd(3'd2, v); chk("R1 enable not writable", v, 32'h00F0_00F0);
    rd(3'd4, v); chk("R1 set reads zero", v, 0);

    // R5 / R6 level line 0, not enabled
    irq_in[0] = 1'b1; idle(1);
    rd(3'd0, v); chk("R5 level sets", v, 32'h1);
    rd(3'd1, v); chk("R6 pending masked", v, 0);
    wr(3'd3, 32'h1); rd(3'd0, v); chk("R5 level re-sets", v, 32'h1);
    irq_in[0] = 1'b0; wr(3'd3, 32'h1); rd(3'd0, v); chk("R4 ack clears", v, 0);

    // R5 edge line 4 (enabled), level line 20 (enabled)
    irq_in[4] = 1'b1; idle(1);
    rd(3'd0, v); chk("R5 edge sets", v, 32'h10);
    rd(3'd1, v); chk("R6 pending", v, 32'h10);
    irq_in[20] = 1'b1; idle(1);
    rd(3'd6, v); chk("R7 lowest wins", v, 4);

    // R8 master gating
    wr(3'd7, 32'h1); idle(2); chk("R8 only global", 32'(irq_out), 0);
    wr(3'd7, 32'h2); idle(2); chk("R8 only line", 32'(irq_out), 0);
    wr(3'd7, 32'h3); idle(2); chk("R8 both on", 32'(irq_out), 1);
    rd(3'd7, v); chk("R8 master read", v, 3);

    wr(3'd3, 32'h10);
    rd(3'd0, v); chk("R5 edge held no re-set", v, 32'h0010_0000);
    rd(3'd6, v); chk("R7 next vector", v, 20);
    irq_in[4] = 1'b0; irq_in[20] = 1'b0;
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd0, v); chk("R4 ack all", v, 0);
    rd(3'd6, v); chk("R7 none pending", v, 32'hFFFF_FFFF);
    idle(1); chk("R8 idle low", 32'(irq_out), 0);

    // R4 request and acknowledge in the same clock
    @(negedge clk);
    bus_addr = 3'd3; bus_wdata = 32'h40; bus_we = 1'b1; irq_in[6] = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    rd(3'd0, v); chk("R4 new edge beats ack", v, 32'h40);
    wr(3'd0, 32'h0); rd(3'd0, v); chk("R1 status not writable", v, 32'h40);
    irq_in[6] = 1'b0; wr(3'd3, 32'h40);

    // random traffic, compared every clock against the model
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      bus_addr  = 3'($urandom_range(0, 7));
      bus_we    = ($urandom_range(0, 2) == 0);
      bus_wdata = $urandom;
      if ($urandom_range(0, 3) == 0) irq_in = NIN'($urandom);
      if (n == 2000) rst = 1'b1;
      if (n == 2003) rst = 1'b0;
    end
    @(negedge clk);
    bus_we = 1'b0;
    idle(2);
    finish_run();
  end
endmodule